// File: doc/BRIEF.md
# Resonant Lamp Inverter Start and Run Sequencer

This block controls a half-bridge inverter that feeds a series-resonant lamp load. It drives two gate signals in anti-phase at a fixed 50 percent duty, less a dead band. Lamp power is set only through the switching period. The period is held as a half-period count in clock ticks.

The block waits until the power-factor stage reports that its regulation loop is running. It then preheats the filaments at the highest frequency and counts the lamps from the preheat current. Next it slews the period slowly upward to the ignition frequency and holds it there. It then checks two things: the lamp current has risen and the rectified lamp voltage has collapsed. On success it ramps on to full power and regulates the frequency against a preset current reference. Failed strikes, overcurrent, an empty fixture, a lamp dropping out and a lamp being replaced each have their own recovery path or latched fault.

All times are in clock ticks and all levels are ADC codes, set by parameters. The frequency slew is one half-period tick every `SWEEP_DIV` clocks.

Top module: `lamp_sequencer`

## Requirements
- R1: After reset, and whenever `pfc_ok` is low, both gates are low one clock after `pfc_ok` is sampled low. After reset `lamp_count` is 0, `fault` is 0 and `pfc_enable` is 1. When `pfc_ok` returns, the sequence restarts from preheat.
- R2: `gate_hi` and `gate_lo` are never high together. For a half period of H ticks and a dead time of D ticks, each gate is high for H-D consecutive ticks once per 2H-tick period.
- R3: Preheat runs with H=`PRE_HP` for `PREHEAT_TICKS`. Then `lamp_i` is summed over 15 consecutive clocks. A sum above 15x`TWO_LAMP_CODE` gives `lamp_count`=2 (code 2). A sum below 15x`EMPTY_CODE` gives `lamp_count`=0 and a latched fault. Any other sum gives `lamp_count`=1.
- R4: During the strike sweep, `igniting` is 1 and H rises by 1 every `SWEEP_DIV` clocks until it reaches `IGN_HP`. It then holds at `IGN_HP` for `HOLD_TICKS`.
- R5: At the end of the hold, the strike is proven if `lamp_i` is above `IGN2_CODE` (two lamps) or above `IGN1_CODE` (one lamp), and `lamp_v` is below `VCOLL_CODE`. On a proven strike, H ramps at the sweep rate to `RUN_MAX_HP` and `running` becomes 1.
- R6: On an unproven strike, the block reheats at H=`REHEAT_HP` for `REHEAT_TICKS` and then sweeps again. After `MAX_TRIES` unproven strikes in a row, `fault` latches with both gates low and `pfc_enable` still 1.
- R7: In run, every `SWEEP_DIV` clocks the block compares `lamp_i` with a reference. The reference is `power_ref` for two lamps and `power_ref`/2 for one lamp. If `lamp_i` is above the reference, H falls by 1. If it is below, H rises by 1. H is clamped to `RUN_MIN_HP`..`RUN_MAX_HP`.
- R8: In run, if 10x`lamp_i` exceeds 11x the reference, both gates go low for `OFF_TICKS` and the block restarts with reheat. On the `OC_LIMIT`-th such event, `fault` latches and `pfc_enable` goes low.
- R9: In run with two lamps, if 10x`lamp_i` is below 8x the reference, `lamp_count` becomes 1 and H falls by 1.
- R10: In run with one lamp, if 10x`lamp_i` exceeds 12x the reference, `lamp_count` becomes 2, `running` drops and the sequence restarts at preheat with H=`PRE_HP`.
- R11: Once set, `fault` stays set until reset, whatever `pfc_ok` does, and both gates stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfc_ok | input | 1 | Power-factor stage loop running |
| lamp_i | input | ADC_W | Lamp current ADC code |
| lamp_v | input | ADC_W | Rectified lamp voltage ADC code |
| power_ref | input | ADC_W | Preset run current for two lamps |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| lamp_count | output | 2 | Detected lamps: 0, 1 or 2 |
| igniting | output | 1 | Strike sweep or hold in progress |
| running | output | 1 | Closed-loop run state |
| fault | output | 1 | Latched fault |
| pfc_enable | output | 1 | Enable for the power-factor stage |

## Verification
A corrupted half-period register shows up at the gates within one switching period, because the measured high time no longer equals H minus the dead time. The bench therefore reads each phase's frequency from pulse widths. A wrong sequencer state or wrong lamp classification shows within one sweep step, eight clocks, as a change in `running`, `igniting` or `lamp_count`. A miscounted retry or overcurrent counter only appears when a fault latches or fails to latch, so the bench runs those paths all the way to their limits.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
    typedef enum logic [3:0] {
        ST_WAIT, ST_PREHEAT, ST_COUNT, ST_SWEEP, ST_HOLD,
        ST_REHEAT, ST_RAMP, ST_RUN, ST_BRKOFF, ST_FAULT
    } seq_state_e;

    localparam logic [1:0] LAMPS_NONE = 2'd0;
    localparam logic [1:0] LAMPS_ONE  = 2'd1;
    localparam logic [1:0] LAMPS_TWO  = 2'd2;
endpackage

// File: rtl/lseq_gate.sv
module lseq_gate #(
    parameter int HP_W = 10,
    parameter int DEAD = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HP_W-1:0] half,
    output logic            hi,
    output logic            lo
);
    localparam logic [HP_W-1:0] DEAD_T = HP_W'(DEAD);

    typedef struct packed {
        logic [HP_W-1:0] cnt;
        logic            ph;
    } gate_t;

    gate_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt = '0;
            d.ph  = 1'b0;
        end else if (q.cnt >= half - 1'b1) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // dead band sits at the start of each half period
    assign hi = en && !q.ph && (q.cnt >= DEAD_T);
    assign lo = en &&  q.ph && (q.cnt >= DEAD_T);
endmodule

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
    import lamp_seq_pkg::*;
#(
    parameter int ADC_W = 10, parameter int HP_W = 10, parameter int TM_W = 16,
    parameter int PRE_HP = 20, parameter int REHEAT_HP = 21, parameter int IGN_HP = 40,
    parameter int RUN_MIN_HP = 20, parameter int RUN_MAX_HP = 50,
    parameter int PREHEAT_TICKS = 200, parameter int REHEAT_TICKS = 300,
    parameter int HOLD_TICKS = 200, parameter int OFF_TICKS = 4,
    parameter int SWEEP_DIV = 8, parameter int SAMPLES = 15,
    parameter int MAX_TRIES = 3, parameter int OC_LIMIT = 6,
    parameter int TWO_LAMP_CODE = 20, parameter int EMPTY_CODE = 10,
    parameter int IGN2_CODE = 100, parameter int IGN1_CODE = 30, parameter int VCOLL_CODE = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfc_ok,
    input  logic [ADC_W-1:0] lamp_i,
    input  logic [ADC_W-1:0] lamp_v,
    input  logic [ADC_W-1:0] power_ref,
    output logic             bridge_en,
    output logic [HP_W-1:0]  half_per,
    output logic [1:0]       lamp_count,
    output logic             igniting,
    output logic             running,
    output logic             fault,
    output logic             pfc_enable
);
    localparam int SW = ADC_W + 4;
    localparam int MW = ADC_W + 5;
    localparam logic [HP_W-1:0] PRE_H  = HP_W'(PRE_HP);
    localparam logic [HP_W-1:0] REH_H  = HP_W'(REHEAT_HP);
    localparam logic [HP_W-1:0] IGN_H  = HP_W'(IGN_HP);
    localparam logic [HP_W-1:0] MIN_H  = HP_W'(RUN_MIN_HP);
    localparam logic [HP_W-1:0] MAX_H  = HP_W'(RUN_MAX_HP);
    localparam logic [TM_W-1:0] PRE_END  = TM_W'(PREHEAT_TICKS - 1);
    localparam logic [TM_W-1:0] REH_END  = TM_W'(REHEAT_TICKS - 1);
    localparam logic [TM_W-1:0] HOLD_END = TM_W'(HOLD_TICKS - 1);
    localparam logic [TM_W-1:0] OFF_END  = TM_W'(OFF_TICKS - 1);
    localparam logic [TM_W-1:0] STEP_END = TM_W'(SWEEP_DIV - 1);
    localparam logic [TM_W-1:0] SMP_END  = TM_W'(SAMPLES - 1);
    localparam logic [SW-1:0]   SUM_TWO  = SW'(TWO_LAMP_CODE * SAMPLES);
    localparam logic [SW-1:0]   SUM_EMPTY = SW'(EMPTY_CODE * SAMPLES);
    localparam logic [3:0]      TRY_MAX  = 4'(MAX_TRIES);
    localparam logic [3:0]      OC_MAX   = 4'(OC_LIMIT);

    typedef struct packed {
        seq_state_e      st;
        logic [HP_W-1:0] hp;
        logic [TM_W-1:0] tmr;
        logic [SW-1:0]   sum;
        logic [3:0]      tries;
        logic [3:0]      ocn;
        logic [1:0]      lamps;
        logic            flt;
        logic            pfc_en;
    } ctrl_t;

    ctrl_t q, d;

    logic             step, proof;
    logic [SW-1:0]    sum_n;
    logic [ADC_W-1:0] ref_eff;
    logic [MW-1:0]    cur10, ref8, ref11, ref12;

    assign step    = (q.tmr == STEP_END);
    assign sum_n   = q.sum + SW'(lamp_i);
    assign ref_eff = (q.lamps == LAMPS_ONE) ? (power_ref >> 1) : power_ref;
    assign cur10   = MW'(lamp_i) * MW'(10);
    assign ref8    = MW'(ref_eff) * MW'(8);
    assign ref11   = MW'(ref_eff) * MW'(11);
    assign ref12   = MW'(ref_eff) * MW'(12);
    assign proof   = ((q.lamps == LAMPS_TWO) ? (lamp_i > ADC_W'(IGN2_CODE))
                                             : (lamp_i > ADC_W'(IGN1_CODE)))
                     && (lamp_v < ADC_W'(VCOLL_CODE));

    always_comb begin
        d     = q;
        d.tmr = q.tmr + 1'b1;
        if (q.flt) begin
            d.st = ST_FAULT;
        end else if (!pfc_ok && q.st != ST_WAIT) begin
            d.st  = ST_WAIT;
            d.tmr = '0;
        end else begin
            case (q.st)
                ST_WAIT: if (pfc_ok) begin
                    d.st = ST_PREHEAT; d.hp = PRE_H; d.tmr = '0;
                end
                ST_PREHEAT: if (q.tmr == PRE_END) begin
                    d.st = ST_COUNT; d.tmr = '0; d.sum = '0;
                end
                ST_COUNT: begin
                    d.sum = sum_n;
                    if (q.tmr == SMP_END) begin
                        d.tmr = '0;
                        d.st  = ST_SWEEP;
                        if (sum_n > SUM_TWO)        d.lamps = LAMPS_TWO;
                        else if (sum_n < SUM_EMPTY) begin
                            d.lamps = LAMPS_NONE; d.flt = 1'b1; d.st = ST_FAULT;
                        end else                    d.lamps = LAMPS_ONE;
                    end
                end
                ST_SWEEP: if (step) begin
                    d.tmr = '0;
                    if (q.hp < IGN_H) d.hp = q.hp + 1'b1;
                    else              d.st = ST_HOLD;
                end
                ST_HOLD: if (q.tmr == HOLD_END) begin
                    d.tmr = '0;
                    if (proof) begin
                        d.st = ST_RAMP; d.tries = '0;
                    end else if (q.tries + 1'b1 >= TRY_MAX) begin
                        d.flt = 1'b1; d.st = ST_FAULT;
                    end else begin
                        d.tries = q.tries + 1'b1; d.st = ST_REHEAT; d.hp = REH_H;
                    end
                end
                ST_REHEAT: if (q.tmr == REH_END) begin
                    d.st = ST_SWEEP; d.tmr = '0;
                end
                ST_RAMP: if (step) begin
                    d.tmr = '0;
                    if (q.hp < MAX_H) d.hp = q.hp + 1'b1;
                    else              d.st = ST_RUN;
                end
                ST_RUN: if (step) begin
                    d.tmr = '0;
                    if (q.lamps == LAMPS_ONE && cur10 > ref12) begin
                        d.lamps = LAMPS_TWO; d.hp = PRE_H; d.st = ST_PREHEAT;
                    end else if (cur10 > ref11) begin
                        d.ocn = q.ocn + 1'b1;
                        if (q.ocn + 1'b1 >= OC_MAX) begin
                            d.flt = 1'b1; d.pfc_en = 1'b0; d.st = ST_FAULT;
                        end else d.st = ST_BRKOFF;
                    end else if (q.lamps == LAMPS_TWO && cur10 < ref8) begin
                        d.lamps = LAMPS_ONE;
                        if (q.hp > MIN_H) d.hp = q.hp - 1'b1;
                    end else if (lamp_i > ref_eff && q.hp > MIN_H) begin
                        d.hp = q.hp - 1'b1;
                    end else if (lamp_i < ref_eff && q.hp < MAX_H) begin
                        d.hp = q.hp + 1'b1;
                    end
                end
                ST_BRKOFF: if (q.tmr == OFF_END) begin
                    d.st = ST_REHEAT; d.hp = REH_H; d.tmr = '0;
                end
                default: d.st = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_WAIT;
            q.hp     <= PRE_H;
            q.pfc_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bridge_en  = !(q.st inside {ST_WAIT, ST_BRKOFF, ST_FAULT});
    assign half_per   = q.hp;
    assign lamp_count = q.lamps;
    assign igniting   = (q.st == ST_SWEEP) || (q.st == ST_HOLD);
    assign running    = (q.st == ST_RUN);
    assign fault      = q.flt;
    assign pfc_enable = q.pfc_en;
endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer #(
    parameter int ADC_W = 10,
    parameter int HP_W  = 10,
    parameter int DEAD  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfc_ok,
    input  logic [ADC_W-1:0] lamp_i,
    input  logic [ADC_W-1:0] lamp_v,
    input  logic [ADC_W-1:0] power_ref,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic [1:0]       lamp_count,
    output logic             igniting,
    output logic             running,
    output logic             fault,
    output logic             pfc_enable
);
    logic            bridge_en;
    logic [HP_W-1:0] half_per;

    lseq_ctrl #(.ADC_W(ADC_W), .HP_W(HP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pfc_ok(pfc_ok),
        .lamp_i(lamp_i), .lamp_v(lamp_v), .power_ref(power_ref),
        .bridge_en(bridge_en), .half_per(half_per), .lamp_count(lamp_count),
        .igniting(igniting), .running(running), .fault(fault),
        .pfc_enable(pfc_enable)
    );

    lseq_gate #(.HP_W(HP_W), .DEAD(DEAD)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(bridge_en), .half(half_per),
        .hi(gate_hi), .lo(gate_lo)
    );
endmodule

// File: rtl/lamp_sequencer_chk.sv
module lamp_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pfc_ok,
    input logic       gate_hi,
    input logic       gate_lo,
    input logic [1:0] lamp_count,
    input logic       running,
    input logic       fault,
    input logic       pfc_enable
);
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    assert_pfc_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pfc_ok |=> (!gate_hi && !gate_lo));

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    assert_fault_gates_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!gate_hi && !gate_lo));

    assert_pfc_shut_with_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pfc_enable) |-> fault);

    assert_run_has_lamps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (lamp_count != 2'd0 && lamp_count != 2'd3));
endmodule

bind lamp_sequencer lamp_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pfc_ok(pfc_ok), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .lamp_count(lamp_count), .running(running),
    .fault(fault), .pfc_enable(pfc_enable)
);

// File: tb/lamp_sequencer_bench.sv
module lamp_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pfc_ok = 1'b0;
    logic [9:0] lamp_i = '0, lamp_v = '0, power_ref = '0;
    logic       gate_hi, gate_lo, igniting, running, fault, pfc_enable;
    logic [1:0] lamp_count;
    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    lamp_sequencer u_lamp_sequencer (
        .clk(clk), .rst_n(rst_n), .pfc_ok(pfc_ok), .lamp_i(lamp_i),
        .lamp_v(lamp_v), .power_ref(power_ref), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .lamp_count(lamp_count), .igniting(igniting),
        .running(running), .fault(fault), .pfc_enable(pfc_enable)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog expired");
            fails = fails + 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: return igniting;
            1: return running;
            2: return fault;
            3: return pfc_enable;
            4: return lamp_count == 2'd1;
            default: return gate_hi;
        endcase
    endfunction

    task automatic wait_sig(input int which, input logic val, input int tmo, input string req);
        int n = 0;
        while (sig(which) !== val && n < tmo) begin
            @(negedge clk); n++;
        end
        chk(req, int'(sig(which)), int'(val));
    endtask

    // high time of gate_hi, low-side high time and full period
    task automatic meas(output int w_hi, output int w_lo, output int per);
        int n = 0;
        w_hi = 0; w_lo = 0; per = 0;
        while (gate_hi && n < 200) begin @(negedge clk); n++; end
        while (!gate_hi && n < 400) begin @(negedge clk); n++; end
        while (gate_hi) begin @(negedge clk); w_hi++; per++; end
        while (!gate_hi && per < 400) begin
            if (gate_lo) w_lo++;
            @(negedge clk); per++;
        end
    endtask

    task automatic do_reset();
        pfc_ok = 0; lamp_i = 0; lamp_v = 500; power_ref = 150; rst_n = 0;
        cycles(5);
        rst_n = 1;
        cycles(2);
    endtask

    task automatic t_reset_wait();
        int hits = 0;
        do_reset();
        chk("R1 reset lamp_count", lamp_count, 0);
        chk("R1 reset fault", fault, 0);
        chk("R1 reset pfc_enable", pfc_enable, 1);
        lamp_i = 25;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (gate_hi || gate_lo) hits++;
        end
        chk("R1 gates idle while pfc_ok low", hits, 0);
    endtask

    task automatic t_full_start();
        int wh, wl, p;
        pfc_ok = 1;
        cycles(2);
        meas(wh, wl, p);
        chk("R2 R3 preheat high time", wh, 17);
        chk("R2 low-side high time", wl, 17);
        chk("R2 period", p, 40);
        wait_sig(0, 1'b1, 400, "R4 igniting raised");
        chk("R3 two lamps", lamp_count, 2);
        cycles(170);
        meas(wh, wl, p);
        chk("R4 ignition hold high time", wh, 37);
        lamp_i = 150; lamp_v = 5;
        wait_sig(1, 1'b1, 600, "R5 running after proof");
        meas(wh, wl, p);
        chk("R5 full power high time", wh, 47);
        lamp_i = 160;
        cycles(300);
        meas(wh, wl, p);
        chk("R7 clamp at min half period", wh, 17);
        lamp_i = 140;
        cycles(300);
        meas(wh, wl, p);
        chk("R7 clamp at max half period", wh, 47);
    endtask

    task automatic t_single_and_replace();
        int wh, wl, p;
        lamp_i = 100;
        wait_sig(4, 1'b1, 20, "R9 single lamp detected");
        lamp_i = 75;
        cycles(50);
        chk("R9 still running", running, 1);
        lamp_i = 95;
        wait_sig(1, 1'b0, 20, "R10 run left on replacement");
        chk("R10 lamp_count back to two", lamp_count, 2);
        meas(wh, wl, p);
        chk("R10 preheat high time", wh, 17);
        wait_sig(0, 1'b1, 400, "R6 sweep started");
        wait_sig(0, 1'b0, 600, "R6 strike unproven");
        meas(wh, wl, p);
        chk("R6 reheat high time", wh, 18);
        wait_sig(2, 1'b1, 3000, "R6 fault after max tries");
        chk("R6 pfc_enable kept", pfc_enable, 1);
        pfc_ok = 0; cycles(20); pfc_ok = 1; cycles(300);
        chk("R11 fault held", fault, 1);
        chk("R11 gate_hi low", gate_hi, 0);
    endtask

    task automatic t_overcurrent();
        do_reset();
        lamp_i = 25; pfc_ok = 1;
        wait_sig(0, 1'b1, 400, "R3 sweep reached");
        lamp_i = 150; lamp_v = 5;
        wait_sig(1, 1'b1, 800, "R5 running");
        pfc_ok = 0;
        @(negedge clk);
        chk("R1 gates off on pfc drop", int'(gate_hi | gate_lo), 0);
        chk("R1 running off on pfc drop", running, 0);
        lamp_i = 25; pfc_ok = 1;
        wait_sig(0, 1'b1, 400, "R1 restart sweep");
        lamp_i = 150;
        wait_sig(1, 1'b1, 800, "R1 running again");
        lamp_i = 170;
        wait_sig(1, 1'b0, 20, "R8 overcurrent leaves run");
        chk("R8 gates off", int'(gate_hi | gate_lo), 0);
        chk("R8 pfc_enable after first trip", pfc_enable, 1);
        wait_sig(3, 1'b0, 10000, "R8 pfc_enable dropped");
        chk("R8 fault at limit", fault, 1);
    endtask

    task automatic t_count_cases();
        do_reset();
        lamp_i = 15; pfc_ok = 1;
        wait_sig(0, 1'b1, 400, "R3 one-lamp sweep");
        chk("R3 one lamp", lamp_count, 1);
        do_reset();
        lamp_i = 5; pfc_ok = 1;
        cycles(300);
        chk("R3 empty fixture fault", fault, 1);
        chk("R3 empty lamp_count", lamp_count, 0);
    endtask

    initial begin
        t_reset_wait();
        t_full_start();
        t_single_and_replace();
        t_overcurrent();
        t_count_cases();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule